// File: doc/BRIEF.md
# Serial Monitor Entry Controller

This block decides, at the end of reset, whether a small microcontroller starts its serial monitor (debug and programming) session, and which clock the session runs from. While reset is held it looks at three things: the two reset-vector bytes, a coded level on the interrupt pin, and whether a user oscillator trim byte has been programmed. The resulting decision, clock choice and trim value are frozen when reset is released.

When monitor mode has been entered, the block runs the opening handshake with the host. It counts eight security bytes from a byte-wide receive port and compares them with a stored eight-byte key. It then asks an external transmitter to send a break, which is ten zero bit times on the line. When the transmitter reports that the break is finished, the block raises a ready-for-commands flag. The UART bit engine, the oscillator, flash storage and the command interpreter sit outside the block and connect through plain level and byte ports.

In internal-oscillator sessions the interrupt pin must stay at ground. If it leaves ground, a sticky loss-of-session flag is raised.

Top module: `mon_entry_ctrl`

## Requirements
- R1: The reset vector counts as erased only when `vec_hi` and `vec_lo` are both 0xFF. Every other pair counts as programmed.
- R2: `irq_lvl` encoding: 00 = ground, 01 = supply, 10 = high test voltage, 11 = reserved. With a programmed vector, monitor mode is entered only at code 10, and then with the external clock.
- R3: With an erased vector, code 01 or code 10 enters monitor mode with the external clock (`clk_int` = 0).
- R4: With an erased vector, code 00 enters monitor mode with the internal oscillator (`clk_int` = 1). `clk_int` is never 1 when the vector is programmed.
- R5: Code 11 never enters monitor mode, whatever the vector.
- R6: In internal-oscillator mode, `trim_apply` equals `trim_valid`, and `trim_out` is `trim_val` when valid and otherwise the default 0x80. Outside internal mode, `trim_apply` = 0 and `trim_out` = 0.
- R7: `mon_active`, `clk_int`, `trim_apply` and `trim_out` take the values the inputs select in the last cycle `rst` is high. Input changes after release have no effect on them.
- R8: `brk_req` rises in the cycle after the eighth `rx_valid` byte of the session is accepted, and not before. Bytes are accepted only in monitor mode, starting one cycle after reset release.
- R9: `brk_req` stays high until a `brk_done` pulse. In the next cycle `brk_req` falls and `cmd_ready` rises, and `cmd_ready` then stays high until reset.
- R10: Security byte i (i = 0 first) is compared with bits [8i+7:8i] of the key. `sec_pass` becomes 1 together with `brk_req` only if all eight match. The break and ready sequence runs either way.
- R11: In internal-oscillator mode, any `irq_lvl` other than 00 after release sets `session_lost` one cycle later, and it stays set until reset. It is never set in external-clock mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the release latches the mode |
| vec_hi | input | 8 | Reset-vector high byte |
| vec_lo | input | 8 | Reset-vector low byte |
| irq_lvl | input | 2 | Coded interrupt-pin level |
| trim_valid | input | 1 | User trim byte is programmed |
| trim_val | input | 8 | Stored user trim byte |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| brk_done | input | 1 | Transmitter has finished the break |
| mon_active | output | 1 | Monitor mode entered |
| clk_int | output | 1 | Internal oscillator selected |
| trim_apply | output | 1 | Apply the user trim byte |
| trim_out | output | 8 | Trim value to the oscillator |
| brk_req | output | 1 | Request a break from the transmitter |
| cmd_ready | output | 1 | Ready for host commands |
| sec_pass | output | 1 | All eight security bytes matched |
| session_lost | output | 1 | Interrupt pin left ground in internal mode |

## Verification
Some properties are checked by assertions on every cycle:
- the latched mode never changes after release;
- the internal clock is never selected without monitor mode;
- the byte counter never passes eight;
- a break request exists only with a full count;
- the ready flag only follows a break;
- the loss flag is sticky and never set in external mode.

Other behaviour only the scenarios can show: the full decision table over every vector class, pin code and trim state, the exact cycle of the break after the eighth byte, and the key comparison with a wrong byte at each position.

// File: rtl/mon_entry_pkg.sv
package mon_entry_pkg;
  typedef enum logic [1:0] {
    IRQ_GND = 2'b00,
    IRQ_SUP = 2'b01,
    IRQ_HV  = 2'b10,
    IRQ_RSV = 2'b11
  } irq_code_e;

  typedef enum logic [1:0] {
    HS_IDLE    = 2'b00,
    HS_COLLECT = 2'b01,
    HS_BREAK   = 2'b10,
    HS_READY   = 2'b11
  } hs_state_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/mon_entry_decide.sv
module mon_entry_decide
  import mon_entry_pkg::*;
#(
  parameter int          TRIM_W   = 8,
  parameter logic [7:0]  DEF_TRIM = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] vec_hi,
  input  logic [BYTE_W-1:0] vec_lo,
  input  logic [1:0]        irq_lvl,
  input  logic              trim_valid,
  input  logic [TRIM_W-1:0] trim_val,
  output logic              mon_en,
  output logic              clk_int,
  output logic              trim_apply,
  output logic [TRIM_W-1:0] trim_out
);
  logic      erased, enter, int_sel;
  irq_code_e code;

  always_comb begin
    code    = irq_code_e'(irq_lvl);
    erased  = (vec_hi == {BYTE_W{1'b1}}) && (vec_lo == {BYTE_W{1'b1}});
    int_sel = erased && (code == IRQ_GND);
    unique case (code)
      IRQ_HV:  enter = 1'b1;
      IRQ_SUP: enter = erased;
      IRQ_GND: enter = erased;
      default: enter = 1'b0;
    endcase
  end

  // Loads every reset cycle; the value present at release is held.
  always_ff @(posedge clk) begin
    if (rst) begin
      mon_en     <= enter;
      clk_int    <= int_sel;
      trim_apply <= int_sel && trim_valid;
      trim_out   <= int_sel ? (trim_valid ? trim_val : DEF_TRIM[TRIM_W-1:0])
                            : '0;
    end
  end

  a_r7_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(mon_en) && $stable(clk_int) && $stable(trim_out)));
  a_r4_int_implies_entry: assert property (@(posedge clk) disable iff (rst)
    clk_int |-> mon_en);
  a_r6_trim_only_internal: assert property (@(posedge clk) disable iff (rst)
    trim_apply |-> clk_int);
endmodule

// File: rtl/mon_key_check.sv
module mon_key_check
  import mon_entry_pkg::*;
#(
  parameter int                      NBYTES = 8,
  parameter logic [NBYTES*8-1:0]     KEY    = 64'h0123_4567_89AB_CDEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [BYTE_W-1:0] data,
  output logic              full,
  output logic              last,
  output logic              pass
);
  localparam int CW = $clog2(NBYTES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(NBYTES);

  logic [CW-1:0]     cnt;
  logic              mism;
  logic [BYTE_W-1:0] exp_byte;

  always_comb begin
    exp_byte = KEY[cnt*BYTE_W +: BYTE_W];
    full     = (cnt == CNT_MAX);
    last     = take && (cnt == CNT_MAX - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      mism <= 1'b0;
      pass <= 1'b0;
    end else if (take && !full) begin
      cnt  <= cnt + 1'b1;
      mism <= mism || (data != exp_byte);
      if (last) pass <= !mism && (data == exp_byte);
    end
  end

  a_r8_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_MAX);
  a_r10_pass_needs_full: assert property (@(posedge clk) disable iff (rst)
    pass |-> full);
endmodule

// File: rtl/mon_handshake_seq.sv
module mon_handshake_seq
  import mon_entry_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mon_en,
  input  logic last_byte,
  input  logic cnt_full,
  input  logic brk_done,
  output logic collecting,
  output logic brk_req,
  output logic cmd_ready
);
  hs_state_e st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      HS_IDLE:    if (mon_en)    st_nx = HS_COLLECT;
      HS_COLLECT: if (last_byte) st_nx = HS_BREAK;
      HS_BREAK:   if (brk_done)  st_nx = HS_READY;
      default:                   st_nx = HS_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= HS_IDLE;
    else     st <= st_nx;
  end

  assign collecting = (st == HS_COLLECT);
  assign brk_req    = (st == HS_BREAK);
  assign cmd_ready  = (st == HS_READY);

  a_r8_break_after_eight: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> cnt_full);
  a_r9_ready_after_break: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_ready) |-> $past(brk_req));
  a_r9_ready_holds: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |=> cmd_ready);
  a_r5_idle_without_entry: assert property (@(posedge clk) disable iff (rst)
    !mon_en |-> (st == HS_IDLE));
endmodule

// File: rtl/mon_entry_ctrl.sv
module mon_entry_ctrl
  import mon_entry_pkg::*;
#(
  parameter int         NBYTES   = 8,
  parameter logic [63:0] KEY     = 64'h0123_4567_89AB_CDEF,
  parameter logic [7:0] DEF_TRIM = 8'h80
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] vec_hi,
  input  logic [7:0] vec_lo,
  input  logic [1:0] irq_lvl,
  input  logic       trim_valid,
  input  logic [7:0] trim_val,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       brk_done,
  output logic       mon_active,
  output logic       clk_int,
  output logic       trim_apply,
  output logic [7:0] trim_out,
  output logic       brk_req,
  output logic       cmd_ready,
  output logic       sec_pass,
  output logic       session_lost
);
  logic collecting, last_byte, cnt_full;

  mon_entry_decide #(.TRIM_W(8), .DEF_TRIM(DEF_TRIM)) u_decide (
    .clk(clk), .rst(rst), .vec_hi(vec_hi), .vec_lo(vec_lo),
    .irq_lvl(irq_lvl), .trim_valid(trim_valid), .trim_val(trim_val),
    .mon_en(mon_active), .clk_int(clk_int), .trim_apply(trim_apply),
    .trim_out(trim_out)
  );

  mon_key_check #(.NBYTES(NBYTES), .KEY(KEY[NBYTES*8-1:0])) u_key (
    .clk(clk), .rst(rst), .take(rx_valid && collecting), .data(rx_data),
    .full(cnt_full), .last(last_byte), .pass(sec_pass)
  );

  mon_handshake_seq u_seq (
    .clk(clk), .rst(rst), .mon_en(mon_active), .last_byte(last_byte),
    .cnt_full(cnt_full), .brk_done(brk_done), .collecting(collecting),
    .brk_req(brk_req), .cmd_ready(cmd_ready)
  );

  always_ff @(posedge clk) begin
    if (rst)
      session_lost <= 1'b0;
    else if (clk_int && (irq_code_e'(irq_lvl) != IRQ_GND))
      session_lost <= 1'b1;
  end

  a_r11_lost_sticky: assert property (@(posedge clk) disable iff (rst)
    session_lost |=> session_lost);
  a_r11_lost_internal_only: assert property (@(posedge clk) disable iff (rst)
    session_lost |-> clk_int);
endmodule

// File: tb/mon_entry_ctrl_tb.sv
module mon_entry_ctrl_tb;
  localparam logic [63:0] KEY = 64'hA5C3_1E70_9B24_D86F;
  localparam logic [7:0]  DEF = 8'h80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] vec_hi = 8'hFF, vec_lo = 8'hFF, trim_val = 8'h00, rx_data = 8'h00;
  logic [1:0] irq_lvl = 2'b00;
  logic trim_valid = 1'b0, rx_valid = 1'b0, brk_done = 1'b0;
  logic mon_active, clk_int, trim_apply, brk_req, cmd_ready, sec_pass, session_lost;
  logic [7:0] trim_out;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  mon_entry_ctrl #(.NBYTES(8), .KEY(KEY), .DEF_TRIM(DEF)) u_dut (
    .clk(clk), .rst(rst), .vec_hi(vec_hi), .vec_lo(vec_lo), .irq_lvl(irq_lvl),
    .trim_valid(trim_valid), .trim_val(trim_val), .rx_valid(rx_valid),
    .rx_data(rx_data), .brk_done(brk_done), .mon_active(mon_active),
    .clk_int(clk_int), .trim_apply(trim_apply), .trim_out(trim_out),
    .brk_req(brk_req), .cmd_ready(cmd_ready), .sec_pass(sec_pass),
    .session_lost(session_lost)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int c = 0; c < 32; c++) begin
      logic [7:0] h, l, tv_v, b;
      logic [1:0] irq;
      logic tv, erased, ent, intm, wrong;
      int wpos;
      case (c % 4)
        0: begin h = 8'hFF; l = 8'hFF; end
        1: begin h = 8'hFF; l = 8'h00; end
        2: begin h = 8'h7E; l = 8'hFF; end
        default: begin h = 8'h12; l = 8'h34; end
      endcase
      irq = 2'((c / 4) % 4);
      tv = (c >= 16);
      tv_v = 8'h40 + 8'(c);
      wrong = c[0];
      wpos = (c / 2) % 8;
      erased = (h == 8'hFF) && (l == 8'hFF);
      ent = (irq == 2'b10) || (erased && irq <= 2'b01);
      intm = erased && (irq == 2'b00);

      rst = 1'b1; vec_hi = h; vec_lo = l; irq_lvl = irq;
      trim_valid = tv; trim_val = tv_v; brk_done = 1'b0; rx_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      vec_hi = ~h; vec_lo = ~l; trim_valid = ~tv; trim_val = ~tv_v;
      irq_lvl = intm ? 2'b00 : ~irq;
      @(negedge clk);
      check("R1/R2/R3/R5 entry", {31'd0, mon_active}, {31'd0, ent});
      check("R4 internal clock", {31'd0, clk_int}, {31'd0, intm});
      check("R6 trim apply", {31'd0, trim_apply}, {31'd0, intm && tv});
      check("R6 trim value", {24'd0, trim_out},
            {24'd0, intm ? (tv ? tv_v : DEF) : 8'h00});
      check("R7 no break yet", {31'd0, brk_req}, 32'd0);
      check("R7 not ready", {31'd0, cmd_ready}, 32'd0);

      for (int i = 0; i < 8; i++) begin
        b = KEY[i*8 +: 8];
        if (wrong && i == wpos) b = b ^ 8'h01;
        send_byte(b);
        if (i == 6) check("R8 no break after seven", {31'd0, brk_req}, 32'd0);
      end
      check("R8 break after eight", {31'd0, brk_req}, {31'd0, ent});
      check("R10 security result", {31'd0, sec_pass}, {31'd0, ent && !wrong});
      check("R8 not ready during break", {31'd0, cmd_ready}, 32'd0);
      if (ent) begin
        repeat (3) @(negedge clk);
        check("R9 break held", {31'd0, brk_req}, 32'd1);
        brk_done = 1'b1;
        @(negedge clk);
        brk_done = 1'b0;
        check("R9 ready after break", {31'd0, cmd_ready}, 32'd1);
        check("R9 break released", {31'd0, brk_req}, 32'd0);
        send_byte(KEY[7:0] ^ 8'hFF);
        check("R10 extra byte ignored", {31'd0, sec_pass}, {31'd0, !wrong});
        check("R9 ready holds", {31'd0, cmd_ready}, 32'd1);
      end else begin
        brk_done = 1'b1;
        @(negedge clk);
        brk_done = 1'b0;
        check("R5 no ready without entry", {31'd0, cmd_ready}, 32'd0);
      end
      check("R11 no loss while low", {31'd0, session_lost}, {31'd0, !intm && 1'b0});
      irq_lvl = 2'b01;
      @(negedge clk);
      irq_lvl = 2'b00;
      @(negedge clk);
      check("R11 loss flag", {31'd0, session_lost}, {31'd0, intm});
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule